// File: doc/BRIEF.md
# PLL Power-Up and Clock Switchover Sequencer

This block takes a system clock from the raw oscillator onto the PLL output and back again, applying each control change only after the step before it has taken effect. A start request may first change the clock divider ratio. The block then loads the frequency multiplier and waits a first settle time. It turns the PLL on, waits a longer lock time, and finally switches the clock selector. It holds busy until the clock mux reports that the selection took effect. A stop request reverses the switch. It clears the selector, waits for the mux to report the oscillator path, and only then powers the PLL down.

Both settle times are given in microseconds and converted to counts of a reference tick, rounded up so that neither minimum is ever shortened. If the PLL is already powered when a start arrives, the load and both waits are skipped. Each wait on a status handshake has a cycle timeout. When it expires, the block sets a sticky error flag and goes back to idle.

Top module: `pll_switch_seq`

## Requirements
- R1: After synchronous active-low reset: pll_en=0, pll_sel=0, mult_out=0, ratio_out=0 (the 1:1 setting), busy=0, done=0, err=0, phase=0 (idle).
- R2: A start accepted while pll_en=0 and pll_sel=0 copies mult_in into mult_out. pll_en rises no sooner than PRE_T=ceil(PRE_US*TICK_KHZ/1000) reference ticks after that load (100 ticks with the defaults).
- R3: pll_sel rises no sooner than LOCK_T=ceil(LOCK_US*TICK_KHZ/1000) reference ticks after pll_en rises (400 ticks with the defaults), and never while pll_en=0.
- R4: busy rises in the cycle after a start or stop is accepted. After a start, busy stays high until sel_status reads 1. At that edge done pulses high for exactly one cycle and busy falls.
- R5: A start accepted while pll_en=1 and pll_sel=0 does no load and no waits. pll_sel is already 1 in the cycle after acceptance.
- R6: A start with ratio_req=1 writes ratio_in to ratio_out in the cycle after acceptance. The PLL steps, starting with the multiplier load, begin only after both hs_ratio_st and pre_ratio_st equal ratio_out.
- R7: A start with ratio_req=0 leaves ratio_out unchanged.
- R8: A stop accepted while pll_en=1 clears pll_sel in the cycle after acceptance. pll_en stays 1 until sel_status reads 0, then falls with a one-cycle done pulse.
- R9: mult_out never changes while pll_en=1. A start request taken while the PLL is powered keeps the earlier multiplier value.
- R10: start_req and stop_req are ignored while busy=1.
- R11: A start while pll_sel=1, or a stop while pll_en=0, gives done=1 in the cycle after the request, with busy staying 0 and pll_en/pll_sel unchanged.
- R12: If a status wait is not satisfied within POLL_CYC cycles, err is set and stays set until reset. busy falls with no done pulse, and pll_en/pll_sel keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick enable for settle counting |
| start_req | input | 1 | Request to run from the PLL (wins over stop_req) |
| stop_req | input | 1 | Request to return to the oscillator |
| mult_in | input | MW (24) | Multiplier setting to load |
| ratio_req | input | 1 | With start: change divider ratio first |
| ratio_in | input | RW (3) | Target divider ratio code |
| sel_status | input | 1 | Mux feedback: 1 = PLL output is in use |
| hs_ratio_st | input | RW (3) | High-speed divider ratio status |
| pre_ratio_st | input | RW (3) | Prescaler divider ratio status |
| pll_en | output | 1 | PLL power/oscillate enable |
| pll_sel | output | 1 | Clock selector: 1 = PLL output |
| mult_out | output | MW (24) | Latched multiplier value |
| ratio_out | output | RW (3) | Divider ratio setting |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky handshake-timeout flag |
| phase | output | 3 | Current step: 0 idle, 1 ratio wait, 2 pre-enable wait, 3 lock wait, 4 select wait, 5 deselect wait |

## Verification
The hardest situation to reach is the warm start (R5) together with the timeout (R12), because the PLL has to be powered but not selected. A correct stop never leaves that state. The bench reaches it with a mux model whose select-status output can be forced stuck at 1. A stop then clears the selector, times out and leaves pll_en high. Once the status is released, a start takes the short path, and the bench checks that the multiplier is kept and that no settle wait runs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RATIO  = 3'd1,
    PH_PRE    = 3'd2,
    PH_LOCK   = 3'd3,
    PH_SELW   = 3'd4,
    PH_DESELW = 3'd5
  } phase_e;

  // microseconds -> reference ticks, rounded up so the minimum is always met
  function automatic int unsigned ticks_for_us(input int unsigned us,
                                               input int unsigned tick_khz);
    return (us * tick_khz + 999) / 1000;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && !clr && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || hit) cnt <= '0;
    else if (en)              cnt <= cnt + W'(1);
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);

endmodule

// File: rtl/ratio_match.sv
module ratio_match #(
  parameter int RW = 3
) (
  input  logic [RW-1:0] target,
  input  logic [RW-1:0] hs_st,
  input  logic [RW-1:0] pre_st,
  output logic          ok
);
  assign ok = (hs_st == target) && (pre_st == target);
endmodule

// File: rtl/pll_switch_seq.sv
module pll_switch_seq
  import pll_seq_pkg::*;
#(
  parameter int MW       = 24,
  parameter int RW       = 3,
  parameter int TICK_KHZ = 1000,
  parameter int PRE_US   = 100,
  parameter int LOCK_US  = 400,
  parameter int POLL_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic [MW-1:0] mult_in,
  input  logic          ratio_req,
  input  logic [RW-1:0] ratio_in,
  input  logic          sel_status,
  input  logic [RW-1:0] hs_ratio_st,
  input  logic [RW-1:0] pre_ratio_st,
  output logic          pll_en,
  output logic          pll_sel,
  output logic [MW-1:0] mult_out,
  output logic [RW-1:0] ratio_out,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [2:0]    phase
);
  localparam int unsigned PRE_T  = ticks_for_us(PRE_US, TICK_KHZ);
  localparam int unsigned LOCK_T = ticks_for_us(LOCK_US, TICK_KHZ);
  localparam int          TW     = $clog2(max_u(PRE_T, LOCK_T) + 1);
  localparam int          PW     = $clog2(POLL_CYC + 1);

  phase_e        st;
  logic [MW-1:0] mult_pend;

  // named internal events
  logic accept_start, accept_stop, quick_done;
  logic in_settle, settle_hit;
  logic in_poll, poll_pass, poll_to;
  logic ratio_ok;
  logic [TW-1:0] settle_lim;

  assign accept_start = (st == PH_IDLE) && start_req;
  assign accept_stop  = (st == PH_IDLE) && !start_req && stop_req;
  assign quick_done   = (accept_start && pll_sel) || (accept_stop && !pll_en);

  assign in_settle  = (st == PH_PRE) || (st == PH_LOCK);
  assign settle_lim = (st == PH_PRE) ? TW'(PRE_T) : TW'(LOCK_T);

  assign in_poll   = (st == PH_RATIO) || (st == PH_SELW) || (st == PH_DESELW);
  assign poll_pass = ((st == PH_RATIO)  && ratio_ok)   ||
                     ((st == PH_SELW)   && sel_status) ||
                     ((st == PH_DESELW) && !sel_status);

  seq_counter #(.W(TW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_settle),
    .en    (in_settle && tick),
    .limit (settle_lim),
    .hit   (settle_hit)
  );

  seq_counter #(.W(PW)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_poll || poll_pass),
    .en    (in_poll),
    .limit (PW'(POLL_CYC)),
    .hit   (poll_to)
  );

  ratio_match #(.RW(RW)) u_match (
    .target (ratio_out),
    .hs_st  (hs_ratio_st),
    .pre_st (pre_ratio_st),
    .ok     (ratio_ok)
  );

  assign phase = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      pll_en    <= 1'b0;
      pll_sel   <= 1'b0;
      mult_out  <= '0;
      mult_pend <= '0;
      ratio_out <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (quick_done) begin
            done <= 1'b1;
          end else if (accept_start) begin
            busy      <= 1'b1;
            mult_pend <= mult_in;
            if (ratio_req) begin
              ratio_out <= ratio_in;
              st        <= PH_RATIO;
            end else if (pll_en) begin
              pll_sel <= 1'b1;
              st      <= PH_SELW;
            end else begin
              mult_out <= mult_in;
              st       <= PH_PRE;
            end
          end else if (accept_stop) begin
            busy    <= 1'b1;
            pll_sel <= 1'b0;
            st      <= PH_DESELW;
          end
        end
        PH_RATIO: begin
          if (poll_pass) begin
            if (pll_en) begin
              pll_sel <= 1'b1;
              st      <= PH_SELW;
            end else begin
              mult_out <= mult_pend;
              st       <= PH_PRE;
            end
          end else if (poll_to) begin
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= PH_IDLE;
          end
        end
        PH_PRE: begin
          if (settle_hit) begin
            pll_en <= 1'b1;
            st     <= PH_LOCK;
          end
        end
        PH_LOCK: begin
          if (settle_hit) begin
            pll_sel <= 1'b1;
            st      <= PH_SELW;
          end
        end
        PH_SELW: begin
          if (poll_pass) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= PH_IDLE;
          end else if (poll_to) begin
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= PH_IDLE;
          end
        end
        PH_DESELW: begin
          if (poll_pass) begin
            pll_en <= 1'b0;
            done   <= 1'b1;
            busy   <= 1'b0;
            st     <= PH_IDLE;
          end else if (poll_to) begin
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= PH_IDLE;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R2: power-up only at the end of the pre-enable wait
  a_r2_en_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(st == PH_PRE));

  // R3: selector never switches to the PLL while it is off
  a_r3_sel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> pll_en);

  // R4: completion never overlaps busy
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: power-down only after the mux reported the oscillator path
  a_r8_off_after_desel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (!pll_sel && $past(!sel_status)));

  // R9: multiplier frozen while powered
  a_r9_mult_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en) |-> $stable(mult_out));

  // R12: error flag is sticky
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

endmodule

// File: tb/pll_switch_seq_test.sv
module pll_switch_seq_test;
  localparam int MW = 24;
  localparam int RW = 3;
  // settle ticks restated from the requirements: ceil(us * 1000 kHz / 1000)
  localparam int EXP_PRE  = 100;
  localparam int EXP_LOCK = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic          start_req = 1'b0, stop_req = 1'b0;
  logic [MW-1:0] mult_in = '0;
  logic          ratio_req = 1'b0;
  logic [RW-1:0] ratio_in = '0;
  logic          sel_status;
  logic [RW-1:0] hs_ratio_st, pre_ratio_st;
  logic          pll_en, pll_sel, busy, done, err;
  logic [MW-1:0] mult_out;
  logic [RW-1:0] ratio_out;
  logic [2:0]    phase;

  int total = 0;
  int bad   = 0;
  logic stuck_sel = 1'b0;

  always #2 clk = ~clk;

  pll_switch_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_req(start_req), .stop_req(stop_req), .mult_in(mult_in),
    .ratio_req(ratio_req), .ratio_in(ratio_in), .sel_status(sel_status),
    .hs_ratio_st(hs_ratio_st), .pre_ratio_st(pre_ratio_st),
    .pll_en(pll_en), .pll_sel(pll_sel), .mult_out(mult_out),
    .ratio_out(ratio_out), .busy(busy), .done(done), .err(err), .phase(phase)
  );

  // clock mux / divider model: delayed acknowledgements
  logic [4:0]    sel_pipe;
  logic [RW-1:0] rp [0:5];
  always @(posedge clk) begin
    if (!rst_n) begin
      sel_pipe <= '0;
      for (int i = 0; i < 6; i++) rp[i] <= '0;
    end else begin
      sel_pipe <= {sel_pipe[3:0], pll_sel};
      rp[0] <= ratio_out;
      for (int i = 1; i < 6; i++) rp[i] <= rp[i-1];
    end
  end
  assign sel_status   = stuck_sel | sel_pipe[4];
  assign hs_ratio_st  = rp[2];
  assign pre_ratio_st = rp[5];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  // waits for done; checks busy held until then and a one-cycle pulse
  task automatic wait_done(input int lim, input string req);
    int n = 0;
    bit busy_ok = 1'b1;
    while (!done && n < lim) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk); n++;
    end
    chk(done, req, done, 1);
    chk(busy_ok, {req, " busy held"}, busy_ok, 1);
    @(negedge clk);
    chk(!done && !busy, {req, " done one cycle"}, {done, busy}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pll_en && !pll_sel && !busy && !done && !err, "R1 flags",
        {pll_en, pll_sel, busy, done, err}, 0);
    chk(mult_out == 0 && ratio_out == 0 && phase == 0, "R1 values",
        {mult_out, ratio_out, phase}, 0);
  endtask

  task automatic t_cold_start();
    int n;
    mult_in = 24'h012345;
    pulse_start();
    chk(busy, "R4 busy after accept", busy, 1);
    chk(mult_out == 24'h012345, "R2 mult load", mult_out, 24'h012345);
    stop_req = 1'b1;                     // R10: ignored while busy
    @(negedge clk) stop_req = 1'b0;
    n = 2;
    while (!pll_en && n < 3000) begin @(negedge clk); n++; end
    chk(n >= EXP_PRE && n <= EXP_PRE + 1, "R2 pre-enable wait", n, EXP_PRE);
    n = 0;
    while (pll_en && !pll_sel && n < 3000) begin @(negedge clk); n++; end
    chk(n >= EXP_LOCK && n <= EXP_LOCK + 1, "R3 lock wait", n, EXP_LOCK);
    wait_done(100, "R4 select handshake");
    chk(pll_en && pll_sel, "R10 stop ignored while busy", {pll_en, pll_sel}, 3);
    chk(ratio_out == 0, "R7 ratio unchanged", ratio_out, 0);
  endtask

  task automatic t_start_selected();
    pulse_start();
    chk(done && !busy, "R11 start while selected", {done, busy}, 2);
    @(negedge clk);
    chk(!done && !busy && pll_sel && pll_en, "R11 no change", {done, busy, pll_sel, pll_en}, 3);
  endtask

  task automatic t_stop();
    int n = 0;
    bit en_ok = 1'b1;
    pulse_stop();
    chk(!pll_sel && pll_en && busy, "R8 deselect first", {pll_sel, pll_en, busy}, 3);
    while (!done && n < 200) begin
      if (sel_status && !pll_en) en_ok = 1'b0;
      @(negedge clk); n++;
    end
    chk(en_ok, "R8 enable held until status 0", en_ok, 1);
    chk(done && !pll_en, "R8 power-down with done", {done, pll_en}, 2);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic t_stop_off();
    pulse_stop();
    chk(done && !busy && !pll_en, "R11 stop while off", {done, busy, pll_en}, 4);
  endtask

  task automatic t_ratio_start();
    ratio_in  = 3'd3;
    ratio_req = 1'b1;
    mult_in   = 24'h0abcde;
    pulse_start();
    ratio_req = 1'b0;
    chk(ratio_out == 3'd3, "R6 ratio written", ratio_out, 3);
    chk(mult_out == 24'h012345, "R6 no load before status", mult_out, 24'h012345);
    repeat (3) @(negedge clk);
    chk(mult_out == 24'h012345 && !pll_en, "R6 held during ratio wait", mult_out, 24'h012345);
    for (int i = 0; i < 50 && mult_out != 24'h0abcde; i++) @(negedge clk);
    chk(hs_ratio_st == 3 && pre_ratio_st == 3, "R6 status matched at load",
        {hs_ratio_st, pre_ratio_st}, 8'h1b);
    wait_done(3000, "R6 sequence completes");
  endtask

  task automatic t_timeout();
    bit seen_done = 1'b0;
    stuck_sel = 1'b1;
    pulse_stop();
    for (int i = 0; i < 200 && busy; i++) begin
      @(negedge clk);
      if (done) seen_done = 1'b1;
    end
    chk(err && !busy && !seen_done, "R12 timeout error", {err, busy, seen_done}, 4);
    chk(pll_en && !pll_sel, "R12 state kept", {pll_en, pll_sel}, 2);
    stuck_sel = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_warm_start();
    mult_in = 24'h000777;
    pulse_start();
    chk(pll_sel && busy, "R5 select at once", {pll_sel, busy}, 3);
    chk(mult_out == 24'h0abcde, "R9 mult kept while on", mult_out, 24'h0abcde);
    wait_done(20, "R5 no settle waits");
    chk(err, "R12 error sticky", err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cold_start();
    t_start_selected();
    t_stop();
    t_stop_off();
    t_ratio_start();
    t_timeout();
    t_warm_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule